// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level radix page table kept in memory. A client presents one request carrying the virtual address, the access kind (read, write or instruction fetch) and whether the access comes from user mode. The walker then reads one 64-bit table entry per level through a simple memory port. Each level's read address is built from the frame number in the previous entry, or from the root frame input at the top level, together with nine bits of the virtual address.

The walk ends early at a large-page entry. It stops with a fault when an entry is not present or when the combined rights of the walked entries refuse the access. On a successful access it writes the leaf entry back to memory when the accessed or dirty flag needs to change. Only one walk runs at a time. `busy` covers the walk, and a single-cycle `rspValid` pulse carries the physical address or the fault code together with the level at which the walk stopped.

Top module: `pt_walker`

## Requirements
- R1: Level 0 uses virtual address bits 47:39, level 1 bits 38:30, level 2 bits 29:21 and level 3 bits 20:12. The read for a level goes to {table frame, index, 3'b000}. The table frame is `rootFrame` at level 0 and entry bits 51:12 of the previous entry below that. Each read is a one-cycle `memReqValid` pulse, and the next read is issued only after the previous response.
- R2: A leaf at level 3 gives the address {entry bits 51:12, va bits 11:0}.
- R3: An entry with bit 0 (present) clear ends the walk with fault code 1 and `rspLevel` equal to that level. Fault code 0 means no fault. On any fault, `rspPaddr` is zero.
- R4: Rights are ANDed over every entry walked: bit 1 allows writes and bit 2 allows user access. A write (`reqAccess`=1) without write right, or a user access (`reqUser`=1) without user right, ends the walk with fault code 2 at the leaf level, and no entry is written.
- R5: Bit 7 (page size) set at level 1 ends the walk with a 1 GB page, {entry bits 51:30, va bits 29:0}. Set at level 2, it ends the walk with a 2 MB page, {entry bits 51:21, va bits 20:0}. At level 0 the bit is ignored and the walk continues.
- R6: A successful access sets bit 5 (accessed) in the leaf entry. A write also sets bit 6 (dirty). Reads (`reqAccess`=0) and fetches (`reqAccess`=2) need no right other than presence and, in user mode, user access.
- R7: The leaf is written back to its own address, with `memReqWrite` high, only when the updated entry differs from the entry read. The write is acknowledged by `memRspValid` before the result appears.
- R8: `busy` is high from the cycle after a request is accepted until the result cycle. `rspValid` is high for exactly one cycle, during which `busy` is low. A request is accepted only when the walker is idle, and `reqValid` is ignored while a walk runs.
- R9: After reset, `busy`, `rspValid` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVaddr | input | 48 | Virtual address to translate |
| reqAccess | input | 2 | 0 read, 1 write, 2 fetch |
| reqUser | input | 1 | Access is from user mode |
| rootFrame | input | 40 | Frame number of the top-level table |
| memReqValid | output | 1 | One-cycle memory request strobe |
| memReqWrite | output | 1 | Request is a write of the leaf entry |
| memReqAddr | output | 52 | Byte address of the entry |
| memReqData | output | 64 | Updated entry for a write |
| memRspValid | input | 1 | Read data valid or write acknowledged |
| memRspData | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | Result pulse |
| rspPaddr | output | 52 | Translated physical address |
| rspFault | output | 2 | 0 none, 1 not present, 2 protection |
| rspLevel | output | 2 | Level at which the walk ended |

## Verification
The hardest cases to reach are the ones where a right is missing at an upper level while the leaf grants it, and the one where a request arrives mid-walk. Entries look ordinary one by one in both, so a design that checks only the leaf or latches every request would go unnoticed. The bench builds tables in which an intermediate entry clears the user right, or the write right, above a permissive leaf. It also pulses a second request, which would fault if taken, in the middle of a walk, and it reports any extra result. A path with the page-size bit set at level 0 and the repeated accesses to an already accessed or dirty leaf check that the bit is ignored at the top and that write-back is skipped when nothing changes.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACC     = 5;
  localparam int BIT_DIRTY   = 6;
  localparam int BIT_PSIZE   = 7;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_MISS = 2'd1;
  localparam logic [1:0] FLT_PROT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RDW, S_EVAL, S_WR, S_WRW, S_DONE
  } walkState_t;

  typedef struct packed {
    logic       loadReq;
    logic       captureEntry;
    logic       stepDown;
    logic       finishOk;
    logic       finishFault;
    logic [1:0] faultCode;
  } walkStrobe_t;

  typedef struct packed {
    logic present;
    logic leaf;
    logic permOk;
    logic needWrite;
  } walkStatus_t;

endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 52,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int OFF_W      = 12,
  parameter int ENTRY_W    = 64,
  parameter int LARGE_MIN  = 1,
  localparam int LVL_W     = $clog2(LEVELS),
  localparam int FRAME_W   = PA_W - OFF_W,
  localparam int ENT_SHIFT = $clog2(ENTRY_W / 8)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  walkStrobe_t          stb,
  input  logic [VA_W-1:0]      reqVaddr,
  input  logic [1:0]           reqAccess,
  input  logic                 reqUser,
  input  logic [FRAME_W-1:0]   rootFrame,
  input  logic [ENTRY_W-1:0]   memRspData,
  output walkStatus_t          sts,
  output logic [PA_W-1:0]      entryAddr,
  output logic [ENTRY_W-1:0]   updEntry,
  output logic [PA_W-1:0]      outPaddr,
  output logic [1:0]           outFault,
  output logic [LVL_W-1:0]     outLevel
);

  logic [VA_W-1:0]    vaReg;
  logic               isWrite;
  logic               isUser;
  logic [LVL_W-1:0]   level;
  logic [FRAME_W-1:0] baseFrame;
  logic [ENTRY_W-1:0] entryReg;
  logic               rwAll;
  logic               usAll;

  logic [IDX_W-1:0]   curIdx;
  logic [PA_W-1:0]    offMask;
  logic [PA_W-1:0]    leafBase;
  logic [PA_W-1:0]    vaWide;

  // index of the current level, most significant level first
  always_comb begin
    curIdx = vaReg[OFF_W + IDX_W * (LEVELS - 1 - int'(level)) +: IDX_W];
  end

  assign entryAddr = {baseFrame, curIdx, {ENT_SHIFT{1'b0}}};

  // offset width grows by one index field per level above the last
  always_comb begin
    offMask = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (int'(level) == l)
        offMask = (PA_W'(1) << (OFF_W + IDX_W * (LEVELS - 1 - l))) - PA_W'(1);
    end
  end

  assign leafBase = {entryReg[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign vaWide   = PA_W'(vaReg);

  always_comb begin
    updEntry = entryReg;
    updEntry[BIT_ACC] = 1'b1;
    if (isWrite) updEntry[BIT_DIRTY] = 1'b1;
  end

  always_comb begin
    sts.present   = entryReg[BIT_PRESENT];
    sts.leaf      = (int'(level) == LEVELS - 1) ||
                    (entryReg[BIT_PSIZE] && int'(level) >= LARGE_MIN);
    sts.permOk    = !(isWrite && !rwAll) && !(isUser && !usAll);
    sts.needWrite = (updEntry != entryReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      isWrite   <= 1'b0;
      isUser    <= 1'b0;
      level     <= '0;
      baseFrame <= '0;
      entryReg  <= '0;
      rwAll     <= 1'b1;
      usAll     <= 1'b1;
    end else begin
      if (stb.loadReq) begin
        vaReg     <= reqVaddr;
        isWrite   <= (reqAccess == ACC_WRITE);
        isUser    <= reqUser;
        level     <= '0;
        baseFrame <= rootFrame;
        rwAll     <= 1'b1;
        usAll     <= 1'b1;
      end
      if (stb.captureEntry) begin
        entryReg <= memRspData;
        rwAll    <= rwAll & memRspData[BIT_WRITE];
        usAll    <= usAll & memRspData[BIT_USER];
      end
      if (stb.stepDown) begin
        level     <= level + LVL_W'(1);
        baseFrame <= entryReg[PA_W-1:OFF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPaddr <= '0;
      outFault <= FLT_NONE;
      outLevel <= '0;
    end else if (stb.finishOk) begin
      outPaddr <= (leafBase & ~offMask) | (vaWide & offMask);
      outFault <= FLT_NONE;
      outLevel <= level;
    end else if (stb.finishFault) begin
      outPaddr <= '0;
      outFault <= stb.faultCode;
      outLevel <= level;
    end
  end

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  walkStatus_t sts,
  output walkStrobe_t stb,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        busy,
  output logic        rspValid
);

  walkState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt         = st;
    stb         = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        stb.loadReq = 1'b1;
        nxt = S_RD;
      end
      S_RD: begin
        memReqValid = 1'b1;
        nxt = S_RDW;
      end
      S_RDW: if (memRspValid) begin
        stb.captureEntry = 1'b1;
        nxt = S_EVAL;
      end
      S_EVAL: begin
        if (!sts.present) begin
          stb.finishFault = 1'b1;
          stb.faultCode   = FLT_MISS;
          nxt = S_DONE;
        end else if (!sts.leaf) begin
          stb.stepDown = 1'b1;
          nxt = S_RD;
        end else if (!sts.permOk) begin
          stb.finishFault = 1'b1;
          stb.faultCode   = FLT_PROT;
          nxt = S_DONE;
        end else if (sts.needWrite) begin
          nxt = S_WR;
        end else begin
          stb.finishOk = 1'b1;
          nxt = S_DONE;
        end
      end
      S_WR: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        nxt = S_WRW;
      end
      S_WRW: if (memRspValid) begin
        stb.finishOk = 1'b1;
        nxt = S_DONE;
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign rspValid = (st == S_DONE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W      = 48,
  parameter int PA_W      = 52,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int OFF_W     = 12,
  parameter int ENTRY_W   = 64,
  parameter int LARGE_MIN = 1,
  localparam int LVL_W    = $clog2(LEVELS),
  localparam int FRAME_W  = PA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [1:0]         reqAccess,
  input  logic               reqUser,
  input  logic [FRAME_W-1:0] rootFrame,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [ENTRY_W-1:0] memReqData,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               busy,
  output logic               rspValid,
  output logic [PA_W-1:0]    rspPaddr,
  output logic [1:0]         rspFault,
  output logic [LVL_W-1:0]   rspLevel
);

  walkStrobe_t stb;
  walkStatus_t sts;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .sts         (sts),
    .stb         (stb),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .busy        (busy),
    .rspValid    (rspValid)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .ENTRY_W(ENTRY_W), .LARGE_MIN(LARGE_MIN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .reqUser    (reqUser),
    .rootFrame  (rootFrame),
    .memRspData (memRspData),
    .sts        (sts),
    .entryAddr  (memReqAddr),
    .updEntry   (memReqData),
    .outPaddr   (rspPaddr),
    .outFault   (rspFault),
    .outLevel   (rspLevel)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W    = 52,
  parameter int ENTRY_W = 64,
  parameter int LVL_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               memReqValid,
  input logic               memReqWrite,
  input logic [ENTRY_W-1:0] memReqData,
  input logic               busy,
  input logic               rspValid,
  input logic [PA_W-1:0]    rspPaddr,
  input logic [1:0]         rspFault,
  input logic [LVL_W-1:0]   rspLevel
);

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R1

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPaddr == '0)); // R3

  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'd3)); // R3

  AST_WRITE_SETS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    memReqWrite |-> (memReqValid && memReqData[5])); // R6

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R8

  AST_RSP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy); // R8

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy); // R8

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R8

  AST_LEVEL_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !rspValid && !$past(rspValid)) |-> $stable(rspLevel)); // R8

endmodule

bind pt_walker pt_walker_chk #(
  .PA_W(PA_W), .ENTRY_W(ENTRY_W), .LVL_W(LVL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .memReqValid (memReqValid),
  .memReqWrite (memReqWrite),
  .memReqData  (memReqData),
  .busy        (busy),
  .rspValid    (rspValid),
  .rspPaddr    (rspPaddr),
  .rspFault    (rspFault),
  .rspLevel    (rspLevel)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [47:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic [39:0] rootFrame = 40'h1;
  logic        memReqValid, memReqWrite;
  logic [51:0] memReqAddr;
  logic [63:0] memReqData;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        busy, rspValid;
  logic [51:0] rspPaddr;
  logic [1:0]  rspFault;
  logic [1:0]  rspLevel;

  always #10 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqUser(reqUser), .rootFrame(rootFrame),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .busy(busy), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspLevel(rspLevel)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [51:0]];
  int          lat = 1;
  int          rdCnt = 0;
  logic [51:0] rdLog [4];
  int          wrCnt = 0;
  logic [51:0] wrAddr = '0;
  logic [63:0] wrData = '0;

  function automatic logic [63:0] rdMem(logic [51:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        logic [51:0] a;
        logic        w;
        logic [63:0] d;
        a = memReqAddr; w = memReqWrite; d = memReqData;
        repeat (lat) @(negedge clk);
        if (w) begin
          mem[a] = d; wrCnt++; wrAddr = a; wrData = d;
          memRspData = 64'h0;
        end else begin
          if (rdCnt < 4) rdLog[rdCnt] = a;
          rdCnt++;
          memRspData = rdMem(a);
        end
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // ---------------- reference model ----------------
  typedef struct {
    logic [51:0] paddr;
    logic [1:0]  fault;
    logic [1:0]  level;
    int          reads;
    logic [51:0] rd [4];
    bit          wr;
    logic [51:0] wa;
    logic [63:0] wd;
    string       tag;
  } exp_t;

  function automatic exp_t refWalk(logic [47:0] va, logic [1:0] acc, bit usr, string tag);
    exp_t e;
    logic [51:0] base;
    bit rw, us;
    e.paddr = '0; e.fault = 0; e.level = 0; e.reads = 0; e.wr = 0;
    e.wa = '0; e.wd = '0; e.tag = tag;
    for (int k = 0; k < 4; k++) e.rd[k] = '0;
    base = {rootFrame, 12'h0};
    rw = 1; us = 1;
    for (int lvl = 0; lvl < 4; lvl++) begin
      logic [51:0] a;
      logic [63:0] ent;
      bit leaf;
      a = {base[51:12], va[47 - 9*lvl -: 9], 3'b000};
      e.rd[lvl] = a;
      e.reads++;
      ent = rdMem(a);
      e.level = 2'(lvl);
      if (!ent[0]) begin e.fault = 2'd1; return e; end
      rw = rw & ent[1];
      us = us & ent[2];
      leaf = (lvl == 3) || (ent[7] && (lvl == 1 || lvl == 2));
      if (leaf) begin
        logic [63:0] ne;
        if ((acc == 2'd1 && !rw) || (usr && !us)) begin e.fault = 2'd2; return e; end
        ne = ent | 64'h20 | ((acc == 2'd1) ? 64'h40 : 64'h0);
        e.wr = (ne != ent); e.wa = a; e.wd = ne;
        if (lvl == 1)      e.paddr = {ent[51:30], va[29:0]};
        else if (lvl == 2) e.paddr = {ent[51:21], va[20:0]};
        else               e.paddr = {ent[51:12], va[11:0]};
        return e;
      end
      base = {ent[51:12], 12'h0};
    end
    return e;
  endfunction

  exp_t expQ [$];

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) begin
          chk("R8 unexpected result", 64'(rspPaddr), 64'hX);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk({e.tag, " paddr"}, 64'(rspPaddr), 64'(e.paddr));
          chk({e.tag, " fault"}, 64'(rspFault), 64'(e.fault));
          chk({e.tag, " level"}, 64'(rspLevel), 64'(e.level));
          chk({"R1 ", e.tag, " read count"}, 64'(rdCnt), 64'(e.reads));
          for (int k = 0; k < e.reads && k < 4; k++)
            chk({"R1 ", e.tag, " read addr"}, 64'(rdLog[k]), 64'(e.rd[k]));
          chk({"R7 ", e.tag, " write count"}, 64'(wrCnt), e.wr ? 64'd1 : 64'd0);
          if (e.wr) begin
            chk({"R7 ", e.tag, " write addr"}, 64'(wrAddr), 64'(e.wa));
            chk({"R6 ", e.tag, " write data"}, wrData, e.wd);
          end
          chk("R8 busy low with result", 64'(busy), 64'd0);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic walk(logic [47:0] va, logic [1:0] acc, bit usr, string tag,
                      bit poke = 0, logic [47:0] pokeVa = '0);
    @(negedge clk);
    while (busy || rspValid) @(negedge clk);
    expQ.push_back(refWalk(va, acc, usr, tag));
    rdCnt = 0; wrCnt = 0;
    reqVaddr = va; reqAccess = acc; reqUser = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      @(negedge clk);
      reqVaddr = pokeVa; reqAccess = 2'd1; reqUser = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [47:0] mkVa(int i0, int i1, int i2, int i3, int off);
    return {9'(i0), 9'(i1), 9'(i2), 9'(i3), 12'(off)};
  endfunction

  function automatic logic [63:0] ent(logic [51:0] pa, logic [11:0] fl);
    return {12'h0, pa[51:12], fl};
  endfunction

  localparam logic [11:0] P = 12'h1, RW = 12'h2, US = 12'h4, PS = 12'h80;
  localparam logic [11:0] ALL = 12'h7;

  initial begin
    mem[52'h1000 + 1*8]  = ent(52'h2000, ALL);
    mem[52'h2000 + 2*8]  = ent(52'h3000, ALL);
    mem[52'h3000 + 3*8]  = ent(52'h4000, ALL);
    mem[52'h4000 + 4*8]  = ent(52'hABCDE000, ALL);
    mem[52'h4000 + 5*8]  = ent(52'h77777000, P | US);
    mem[52'h4000 + 6*8]  = 64'h0;
    mem[52'h3000 + 7*8]  = ent(52'h40000000, ALL | PS);
    mem[52'h2000 + 8*8]  = ent(52'h80000000, ALL | PS);
    mem[52'h2000 + 10*8] = ent(52'h5000, P | RW);
    mem[52'h5000]        = ent(52'h6000, ALL);
    mem[52'h6000]        = ent(52'h99999000, ALL);
    mem[52'h1000 + 11*8] = ent(52'h2000, ALL | PS);
    mem[52'h3000 + 12*8] = ent(52'h4000, P | US);

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy in reset", 64'(busy), 64'd0);
    chk("R9 rspValid in reset", 64'(rspValid), 64'd0);
    chk("R9 memReqValid in reset", 64'(memReqValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", 64'(busy), 64'd0);

    lat = 1;
    walk(mkVa(1, 2, 3, 4, 'h123), 2'd0, 1, "R2 R6 user read sets accessed");
    walk(mkVa(1, 2, 3, 4, 'h456), 2'd0, 1, "R7 repeat read no writeback");
    lat = 2;
    walk(mkVa(1, 2, 3, 4, 'hFFF), 2'd1, 0, "R6 write sets dirty");
    walk(mkVa(1, 2, 3, 4, 'h001), 2'd1, 0, "R7 repeat write no writeback");
    walk(mkVa(1, 2, 3, 5, 'h010), 2'd2, 1, "R6 user fetch read-only page");
    walk(mkVa(1, 2, 3, 5, 'h020), 2'd1, 1, "R4 write to read-only page");
    lat = 3;
    walk(mkVa(1, 2, 3, 6, 'h0), 2'd0, 0, "R3 not present at level 3");
    walk(mkVa(9, 0, 0, 0, 'h0), 2'd0, 0, "R3 not present at level 0");
    lat = 1;
    walk(mkVa(1, 2, 7, 'h1AB, 'h456), 2'd0, 0, "R5 2MB page");
    walk(mkVa(1, 8, 'h155, 'h0AA, 'h321), 2'd1, 1, "R5 1GB page write");
    walk(mkVa(1, 10, 0, 0, 'h8), 2'd0, 1, "R4 user right cleared above leaf");
    walk(mkVa(1, 10, 0, 0, 'h8), 2'd0, 0, "R4 supervisor passes same path");
    walk(mkVa(11, 2, 3, 4, 'h55), 2'd0, 0, "R5 size bit ignored at level 0");
    walk(mkVa(1, 2, 12, 4, 'h0), 2'd1, 0, "R4 write right cleared above leaf");
    lat = 2;
    walk(mkVa(1, 2, 3, 4, 'h7), 2'd0, 0, "R8 request ignored while busy",
         1, mkVa(9, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk("R8 no leftover results", 64'(expQ.size()), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule